// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block is the write-side protocol engine of a parallel NOR flash model. Every bus write is taken as one cycle of a command handshake. The sequencer checks each cycle against the expected unlock pattern. It then decodes program, erase, identification, query and fast-program (bypass) commands. It also applies the resulting changes to a small register-based storage array. A read port returns array words for the read path. The current protocol state, the bypass flag, the data-polling bit and an erase-busy flag are published as outputs.

Programming can only clear bits. Erasing sets a whole sector, or the whole array, to all ones. Erases then hold the sequencer busy for a fixed number of clock cycles. A read-only input blocks every array change, while the protocol still steps through its states as usual.

Top module: `nor_cmd_sequencer`

## Requirements
- R1: After reset, mode is 0 (read), bypass_on is 0, poll_bit is 0 and every array byte reads 0xFF.
- R2: The write word offset is the byte address modulo the chip size, divided by BUS_BYTES. Unlock address A is offset UNLOCK_A (default 0x55) and unlock address B is UNLOCK_B (default 0xAA). Commands are taken from wr_data[7:0].
- R3: In mode 0, 0xAA at unlock address A moves to mode 1. In mode 1, 0x55 at unlock address B moves to mode 2. Any other write in these modes returns to mode 0 and clears bypass.
- R4: In mode 2 the write must be at unlock address A; this check is skipped when bypass_on is 1. The decoded command selects the next state: 0x20 sets bypass_on and stays in mode 2, 0x80 goes to mode 5, 0x90 goes to mode 3, and 0xA0 goes to mode 4. Any other byte returns to mode 0 with bypass cleared.
- R5: In mode 4, the next write ANDs wr_data into the addressed word, with byte i on bits 8i+7..8i. poll_bit becomes the inverse of wr_data[7]. The mode then returns to 2 if bypass_on is 1, and to 0 otherwise.
- R6: A write of 0xF0 returns to mode 0 and clears bypass. This holds in every mode except 4 (where it is program data) and 8/9 (busy).
- R7: Erase setup runs as follows. In mode 5, 0xAA at address A moves to mode 6. In mode 6, 0x55 at address B moves to mode 7. In mode 7, 0x10 at address A sets every byte to 0xFF and enters mode 8. Also in mode 7, 0x30 sets every byte of the addressed sector to 0xFF and enters mode 9. Anything else returns to mode 0.
- R8: Modes 8 and 9 ignore all writes, and busy is 1 while in them. The erase command clears poll_bit. Exactly CHIP_ERASE_CYCLES or SECTOR_ERASE_CYCLES clock edges after the command, poll_bit inverts. At the same point the mode becomes 2 if bypass is set, and 0 otherwise.
- R9: In mode 3, a write of 0x00 with bypass_on at 1 exits to mode 0 and clears bypass. 0x98 at offset 0x55 enters mode 10. Any other write returns to mode 0.
- R10: In mode 0, 0x98 at offset 0x55 enters mode 10 (query). Any write in mode 10 returns to mode 0.
- R11: While ro_lock is 1, no array byte changes, but mode and poll_bit still follow R3 to R9.
- R12: rd_data is the word at rd_addr modulo the chip size, aligned down to BUS_BYTES, in little-endian byte order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ro_lock | input | 1 | Blocks all array modification |
| wr_en | input | 1 | Write strobe, one bus write per cycle |
| wr_addr | input | BUS_ADDR_W | Write byte address |
| wr_data | input | 8*BUS_BYTES | Write data / command byte in bits 7:0 |
| rd_addr | input | BUS_ADDR_W | Read byte address |
| rd_data | output | 8*BUS_BYTES | Array word at rd_addr |
| mode | output | 4 | Protocol state code (0 read ... 10 query) |
| bypass_on | output | 1 | Fast-program bypass active |
| poll_bit | output | 1 | Data-polling status bit |
| busy | output | 1 | Erase in progress |

## Verification
A corrupted protocol state shows on the mode output at the clock edge after the write that caused it. It shows on the array at the write after that, as a program or erase landing on the wrong bytes or not at all. A timer that is off by a cycle appears on busy and poll_bit exactly at the expected release edge. The bench therefore samples that edge and the one before it. A lost bypass flag appears on the mode that follows a program or erase, which returns to read instead of the command cycle.

// File: rtl/ncs_pkg.sv
package ncs_pkg;

  typedef enum logic [3:0] {
    M_READ       = 4'd0,
    M_UNLOCK2    = 4'd1,
    M_COMMAND    = 4'd2,
    M_AUTOSEL    = 4'd3,
    M_PROGRAM    = 4'd4,
    M_ER_UNLOCK1 = 4'd5,
    M_ER_UNLOCK2 = 4'd6,
    M_ER_COMMAND = 4'd7,
    M_CHIP_BUSY  = 4'd8,
    M_SECT_BUSY  = 4'd9,
    M_QUERY      = 4'd10
  } mode_e;

  localparam logic [7:0] C_KEY_A      = 8'hAA;
  localparam logic [7:0] C_KEY_B      = 8'h55;
  localparam logic [7:0] C_ABORT      = 8'hF0;
  localparam logic [7:0] C_BYPASS     = 8'h20;
  localparam logic [7:0] C_ERASE_SET  = 8'h80;
  localparam logic [7:0] C_IDENT      = 8'h90;
  localparam logic [7:0] C_PROGRAM    = 8'hA0;
  localparam logic [7:0] C_CHIP_GO    = 8'h10;
  localparam logic [7:0] C_SECT_GO    = 8'h30;
  localparam logic [7:0] C_QUERY      = 8'h98;
  localparam logic [7:0] C_BYP_EXIT   = 8'h00;
  localparam int unsigned QUERY_WORD  = 32'h55;

  typedef struct packed {
    mode_e mode;
    logic  bypass;
    logic  prog;
    logic  chip;
    logic  sector;
  } step_t;

  // byte address -> word offset inside the chip
  function automatic int unsigned word_of(int unsigned byte_addr,
                                          int unsigned chip_bytes,
                                          int unsigned bus_bytes);
    return (byte_addr & (chip_bytes - 1)) / bus_bytes;
  endfunction

  // byte address -> sector index inside the chip
  function automatic int unsigned sector_of(int unsigned byte_addr,
                                            int unsigned chip_bytes,
                                            int unsigned sector_bytes);
    return (byte_addr & (chip_bytes - 1)) / sector_bytes;
  endfunction

endpackage

// File: rtl/ncs_decode.sv
module ncs_decode
  import ncs_pkg::*;
#(
  parameter int OFF_W    = 8,
  parameter int UNLOCK_A = 32'h55,
  parameter int UNLOCK_B = 32'hAA
) (
  input  mode_e            mode,
  input  logic             bypass,
  input  logic             we,
  input  logic [7:0]       cmd,
  input  logic [OFF_W-1:0] off,
  input  logic             tmr_done,
  output step_t            nxt
);
  localparam logic [OFF_W-1:0] OFF_A = OFF_W'(UNLOCK_A);
  localparam logic [OFF_W-1:0] OFF_B = OFF_W'(UNLOCK_B);
  localparam logic [OFF_W-1:0] OFF_Q = OFF_W'(QUERY_WORD);

  logic busy, at_a, at_b, at_q;

  always_comb begin
    busy = (mode == M_CHIP_BUSY) || (mode == M_SECT_BUSY);
    at_a = (off == OFF_A);
    at_b = (off == OFF_B);
    at_q = (off == OFF_Q);
    nxt.mode   = mode;
    nxt.bypass = bypass;
    nxt.prog   = 1'b0;
    nxt.chip   = 1'b0;
    nxt.sector = 1'b0;
    if (tmr_done) begin
      nxt.mode = bypass ? M_COMMAND : M_READ;
    end else if (we && !busy) begin
      // fall-back for every failed check
      nxt.mode   = M_READ;
      nxt.bypass = 1'b0;
      if (!(cmd == C_ABORT && mode != M_PROGRAM)) begin
        unique case (mode)
          M_READ: begin
            if (at_q && cmd == C_QUERY) nxt.mode = M_QUERY;
            else if (at_a && cmd == C_KEY_A) nxt.mode = M_UNLOCK2;
          end
          M_UNLOCK2: if (at_b && cmd == C_KEY_B) begin
            nxt.mode = M_COMMAND; nxt.bypass = bypass;
          end
          M_COMMAND: if (bypass || at_a) begin
            nxt.bypass = bypass;
            unique case (cmd)
              C_BYPASS:    begin nxt.mode = M_COMMAND; nxt.bypass = 1'b1; end
              C_ERASE_SET: nxt.mode = M_ER_UNLOCK1;
              C_IDENT:     nxt.mode = M_AUTOSEL;
              C_PROGRAM:   nxt.mode = M_PROGRAM;
              default:     nxt.bypass = 1'b0;
            endcase
          end
          M_PROGRAM: begin
            nxt.prog   = 1'b1;
            nxt.bypass = bypass;
            nxt.mode   = bypass ? M_COMMAND : M_READ;
          end
          M_AUTOSEL: begin
            if (!(bypass && cmd == C_BYP_EXIT) && at_q && cmd == C_QUERY) begin
              nxt.mode = M_QUERY; nxt.bypass = bypass;
            end
          end
          M_ER_UNLOCK1: if (at_a && cmd == C_KEY_A) begin
            nxt.mode = M_ER_UNLOCK2; nxt.bypass = bypass;
          end
          M_ER_UNLOCK2: if (at_b && cmd == C_KEY_B) begin
            nxt.mode = M_ER_COMMAND; nxt.bypass = bypass;
          end
          M_ER_COMMAND: begin
            if (cmd == C_CHIP_GO && at_a) begin
              nxt.mode = M_CHIP_BUSY; nxt.chip = 1'b1; nxt.bypass = bypass;
            end else if (cmd == C_SECT_GO) begin
              nxt.mode = M_SECT_BUSY; nxt.sector = 1'b1; nxt.bypass = bypass;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ncs_busy_timer.sv
module ncs_busy_timer #(
  parameter int CHIP_CYC = 40,
  parameter int SECT_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_chip,
  input  logic start_sector,
  output logic active,
  output logic done
);
  localparam int MAX_CYC = (CHIP_CYC > SECT_CYC) ? CHIP_CYC : SECT_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  assign done = active && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else if (start_chip) begin
      active <= 1'b1;
      cnt_q  <= CNT_W'(CHIP_CYC - 1);
    end else if (start_sector) begin
      active <= 1'b1;
      cnt_q  <= CNT_W'(SECT_CYC - 1);
    end else if (done) begin
      active <= 1'b0;
    end else if (active) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/ncs_array.sv
module ncs_array #(
  parameter int BUS_BYTES    = 1,
  parameter int SECTOR_BYTES = 64,
  parameter int NUM_SECTORS  = 4,
  parameter int WORD_W       = 8,
  parameter int SEC_W        = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   prog_en,
  input  logic [WORD_W-1:0]      prog_word,
  input  logic [8*BUS_BYTES-1:0] prog_data,
  input  logic                   chip_en,
  input  logic                   sector_en,
  input  logic [SEC_W-1:0]       sector_idx,
  input  logic [WORD_W-1:0]      rd_word,
  output logic [8*BUS_BYTES-1:0] rd_data
);
  localparam int CHIP_BYTES = SECTOR_BYTES * NUM_SECTORS;
  localparam int BUS_BITS   = 8 * BUS_BYTES;

  logic [CHIP_BYTES*8-1:0] flat;

  for (genvar g = 0; g < CHIP_BYTES; g++) begin : g_cell
    localparam int WORD = g / BUS_BYTES;
    localparam int LANE = g % BUS_BYTES;
    localparam int SECT = g / SECTOR_BYTES;
    logic [7:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cell_q <= 8'hFF;
      else if (chip_en || (sector_en && sector_idx == SEC_W'(SECT)))
        cell_q <= 8'hFF;
      else if (prog_en && prog_word == WORD_W'(WORD))
        cell_q <= cell_q & prog_data[8*LANE +: 8];
    end
    assign flat[8*g +: 8] = cell_q;
  end

  assign rd_data = flat[rd_word*BUS_BITS +: BUS_BITS];
endmodule

// File: rtl/nor_cmd_sequencer.sv
module nor_cmd_sequencer
  import ncs_pkg::*;
#(
  parameter int BUS_BYTES          = 1,
  parameter int SECTOR_BYTES       = 64,
  parameter int NUM_SECTORS        = 4,
  parameter int BUS_ADDR_W         = 10,
  parameter int UNLOCK_A           = 32'h55,
  parameter int UNLOCK_B           = 32'hAA,
  parameter int CHIP_ERASE_CYCLES  = 40,
  parameter int SECTOR_ERASE_CYCLES = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ro_lock,
  input  logic                   wr_en,
  input  logic [BUS_ADDR_W-1:0]  wr_addr,
  input  logic [8*BUS_BYTES-1:0] wr_data,
  input  logic [BUS_ADDR_W-1:0]  rd_addr,
  output logic [8*BUS_BYTES-1:0] rd_data,
  output logic [3:0]             mode,
  output logic                   bypass_on,
  output logic                   poll_bit,
  output logic                   busy
);
  localparam int CHIP_BYTES = SECTOR_BYTES * NUM_SECTORS;
  localparam int AW         = $clog2(CHIP_BYTES);
  localparam int LANE_W     = $clog2(BUS_BYTES);
  localparam int OFF_W      = AW - LANE_W;
  localparam int SEC_W      = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1;

  mode_e            mode_q;
  logic             bypass_q, poll_q;
  step_t            nxt;
  logic [OFF_W-1:0] wr_off, rd_off;
  logic [SEC_W-1:0] wr_sec;
  logic             tmr_active;

  // named internal events, observed by the bound checker
  logic ev_prog, ev_chip, ev_sector, tmr_done;

  assign wr_off = OFF_W'(word_of(32'(wr_addr), CHIP_BYTES, BUS_BYTES));
  assign rd_off = OFF_W'(word_of(32'(rd_addr), CHIP_BYTES, BUS_BYTES));
  assign wr_sec = SEC_W'(sector_of(32'(wr_addr), CHIP_BYTES, SECTOR_BYTES));

  ncs_decode #(.OFF_W(OFF_W), .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B)) u_dec (
    .mode(mode_q), .bypass(bypass_q), .we(wr_en), .cmd(wr_data[7:0]),
    .off(wr_off), .tmr_done(tmr_done), .nxt(nxt)
  );

  assign ev_prog   = nxt.prog;
  assign ev_chip   = nxt.chip;
  assign ev_sector = nxt.sector;

  ncs_busy_timer #(.CHIP_CYC(CHIP_ERASE_CYCLES), .SECT_CYC(SECTOR_ERASE_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start_chip(ev_chip), .start_sector(ev_sector),
    .active(tmr_active), .done(tmr_done)
  );

  ncs_array #(.BUS_BYTES(BUS_BYTES), .SECTOR_BYTES(SECTOR_BYTES),
              .NUM_SECTORS(NUM_SECTORS), .WORD_W(OFF_W), .SEC_W(SEC_W)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .prog_en(ev_prog && !ro_lock), .prog_word(wr_off), .prog_data(wr_data),
    .chip_en(ev_chip && !ro_lock), .sector_en(ev_sector && !ro_lock),
    .sector_idx(wr_sec), .rd_word(rd_off), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_READ;
      bypass_q <= 1'b0;
      poll_q   <= 1'b0;
    end else begin
      mode_q   <= nxt.mode;
      bypass_q <= nxt.bypass;
      if (ev_prog)                poll_q <= ~wr_data[7];
      else if (ev_chip || ev_sector) poll_q <= 1'b0;
      else if (tmr_done)          poll_q <= ~poll_q;
    end
  end

  assign mode      = mode_q;
  assign bypass_on = bypass_q;
  assign poll_bit  = poll_q;
  assign busy      = tmr_active;
endmodule

// File: rtl/ncs_checker.sv
module ncs_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic [3:0]    mode,
  input logic          bypass_on,
  input logic          poll_bit,
  input logic          ev_prog,
  input logic          ev_chip,
  input logic          ev_sector,
  input logic          tmr_done
);
  assert_f0_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7:0] == 8'hF0 && mode != 4'd4 && mode != 4'd8 && mode != 4'd9)
    |=> (mode == 4'd0 && !bypass_on));

  assert_prog_poll_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_prog |=> (poll_bit == !$past(wr_data[7])));

  assert_prog_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_prog |=> (mode == ($past(bypass_on) ? 4'd2 : 4'd0)));

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 4'd8 || mode == 4'd9) && !tmr_done)
    |=> ($stable(mode) && $stable(bypass_on) && $stable(poll_bit)));

  assert_done_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_done |=> (poll_bit != $past(poll_bit)));

  assert_query_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd10 && wr_en) |=> (mode == 4'd0));

  assert_erase_enter_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_chip |=> mode == 4'd8) and (ev_sector |=> mode == 4'd9));

  assert_one_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_prog, ev_chip, ev_sector}));
endmodule

bind nor_cmd_sequencer ncs_checker #(.DW(8*BUS_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .mode(mode),
  .bypass_on(bypass_on), .poll_bit(poll_bit), .ev_prog(ev_prog),
  .ev_chip(ev_chip), .ev_sector(ev_sector), .tmr_done(tmr_done)
);

// File: tb/tb_nor_cmd_sequencer.sv
module tb_nor_cmd_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int CHIP_CYC   = 40;
  localparam int SECT_CYC   = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ro_lock = 1'b0;
  logic       wr_en = 1'b0;
  logic [9:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [9:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [3:0] mode;
  logic       bypass_on, poll_bit, busy;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_cmd_sequencer #(.CHIP_ERASE_CYCLES(CHIP_CYC), .SECTOR_ERASE_CYCLES(SECT_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .ro_lock(ro_lock), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .mode(mode),
    .bypass_on(bypass_on), .poll_bit(poll_bit), .busy(busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [9:0] a, output int v);
    rd_addr = a; #1; v = int'(rd_data);
  endtask

  task automatic unlock();
    wr(10'h055, 8'hAA); wr(10'h0AA, 8'h55);
  endtask

  task automatic t_reset();
    int v;
    chk("R1 mode", mode, 0); chk("R1 bypass", bypass_on, 0); chk("R1 poll", poll_bit, 0);
    peek(10'h000, v); chk("R1 byte0", v, 8'hFF);
    peek(10'h0FF, v); chk("R1 byte255", v, 8'hFF);
  endtask

  task automatic t_unlock_rules();
    wr(10'h055, 8'hAA); chk("R3 first key", mode, 1);
    wr(10'h0AA, 8'h54); chk("R3 bad second key", mode, 0);
    wr(10'h054, 8'hAA); chk("R3 bad first address", mode, 0);
    wr(10'h155, 8'hAA); chk("R2 modulo first key", mode, 1);
    wr(10'h2AA, 8'h55); chk("R2 modulo second key", mode, 2);
    wr(10'h355, 8'h77); chk("R4 unknown command", mode, 0);
    unlock(); wr(10'h056, 8'hA0); chk("R4 command wrong address", mode, 0);
  endtask

  task automatic t_program();
    int v;
    unlock(); wr(10'h055, 8'hA0); chk("R4 program command", mode, 4);
    wr(10'h010, 8'h3C);
    peek(10'h010, v); chk("R5 program value", v, 8'h3C);
    chk("R5 poll inverse", poll_bit, 1); chk("R5 back to read", mode, 0);
    unlock(); wr(10'h055, 8'hA0); wr(10'h010, 8'hF0);
    peek(10'h010, v); chk("R5 AND with F0 data", v, 8'h30);
    chk("R6 F0 as data poll", poll_bit, 0);
    peek(10'h110, v); chk("R12 read modulo", v, 8'h30);
  endtask

  task automatic t_abort();
    unlock(); chk("R3 unlocked", mode, 2);
    wr(10'h123, 8'hF0); chk("R6 abort mode", mode, 0);
    unlock(); wr(10'h055, 8'h80); wr(10'h055, 8'hAA);
    wr(10'h000, 8'hF0); chk("R6 abort in erase setup", mode, 0);
  endtask

  task automatic t_sector_erase();
    int v;
    unlock(); wr(10'h055, 8'hA0); wr(10'h041, 8'h00);
    unlock(); wr(10'h055, 8'h80); chk("R4 erase setup", mode, 5);
    wr(10'h055, 8'hAA); chk("R7 second key A", mode, 6);
    wr(10'h0AA, 8'h55); chk("R7 second key B", mode, 7);
    wr(10'h050, 8'h30);
    chk("R7 sector busy mode", mode, 9); chk("R8 poll cleared", poll_bit, 0);
    chk("R8 busy flag", busy, 1);
    peek(10'h041, v); chk("R7 sector filled", v, 8'hFF);
    peek(10'h010, v); chk("R7 other sector kept", v, 8'h30);
    wr(10'h055, 8'hAA); chk("R8 write ignored", mode, 9);
    repeat (SECT_CYC - 2) @(negedge clk);
    chk("R8 still busy last cycle", mode, 9);
    @(negedge clk);
    chk("R8 sector done mode", mode, 0); chk("R8 poll inverted", poll_bit, 1);
    chk("R8 busy released", busy, 0);
  endtask

  task automatic t_chip_erase();
    int v;
    unlock(); wr(10'h055, 8'h80); unlock(); wr(10'h055, 8'h10);
    chk("R7 chip busy mode", mode, 8);
    peek(10'h010, v); chk("R7 chip filled", v, 8'hFF);
    wr(10'h055, 8'hF0); chk("R8 F0 ignored while busy", mode, 8);
    repeat (CHIP_CYC - 2) @(negedge clk);
    chk("R8 chip still busy", mode, 8);
    @(negedge clk);
    chk("R8 chip done", mode, 0); chk("R8 chip poll", poll_bit, 1);
    unlock(); wr(10'h055, 8'h80); unlock(); wr(10'h055, 8'h31);
    chk("R7 bad erase byte", mode, 0);
  endtask

  task automatic t_bypass();
    int v;
    unlock(); wr(10'h055, 8'h20);
    chk("R4 bypass mode", mode, 2); chk("R4 bypass flag", bypass_on, 1);
    wr(10'h003, 8'hA0); chk("R4 bypass skips address", mode, 4);
    wr(10'h020, 8'h5A);
    peek(10'h020, v); chk("R5 bypass program", v, 8'h5A);
    chk("R5 bypass return", mode, 2); chk("R5 bypass kept", bypass_on, 1);
    wr(10'h007, 8'h90); chk("R4 autoselect", mode, 3);
    wr(10'h000, 8'h00); chk("R9 bypass exit mode", mode, 0);
    chk("R9 bypass exit flag", bypass_on, 0);
    unlock(); wr(10'h055, 8'h20); wr(10'h000, 8'hF0);
    chk("R6 F0 clears bypass", bypass_on, 0);
    unlock(); wr(10'h055, 8'h20);
    wr(10'h011, 8'h80); unlock(); wr(10'h060, 8'h30);
    repeat (SECT_CYC) @(negedge clk);
    chk("R8 bypass erase return", mode, 2);
    wr(10'h000, 8'hF0);
  endtask

  task automatic t_query();
    unlock(); wr(10'h055, 8'h90); wr(10'h055, 8'h98);
    chk("R9 query from autoselect", mode, 10);
    wr(10'h000, 8'h12); chk("R10 write leaves query", mode, 0);
    wr(10'h055, 8'h98); chk("R10 query from read", mode, 10);
    wr(10'h055, 8'hAA); chk("R10 any write exits", mode, 0);
    unlock(); wr(10'h055, 8'h90); wr(10'h012, 8'h00);
    chk("R9 other write resets", mode, 0);
  endtask

  task automatic t_readonly();
    int v;
    ro_lock = 1'b1;
    unlock(); wr(10'h055, 8'hA0); wr(10'h020, 8'h00);
    peek(10'h020, v); chk("R11 program blocked", v, 8'h5A);
    chk("R11 protocol runs", mode, 0); chk("R11 poll updated", poll_bit, 1);
    unlock(); wr(10'h055, 8'h80); unlock(); wr(10'h055, 8'h10);
    peek(10'h020, v); chk("R11 erase blocked", v, 8'h5A);
    chk("R11 busy anyway", mode, 8);
    repeat (CHIP_CYC) @(negedge clk);
    ro_lock = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unlock_rules();
    t_program();
    t_abort();
    t_sector_erase();
    t_chip_erase();
    t_bypass();
    t_query();
    t_readonly();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule